// File: doc/BRIEF.md
# PWM Audio DAC Modulator

This block turns a stream of 8-bit unsigned audio samples into a single-bit pulse-width-modulated signal. An external RC low-pass filter smooths that signal into an analog waveform. Two counters run from the system clock. A sample-rate divider sets when the next sample is pulled from a valid/ready stream. A carrier counter sets the PWM period. Each accepted sample becomes the duty cycle of the carrier.

There are two modulation modes. In free mode the carrier period is a fixed 256 clocks, so its rate does not depend on the sample rate. At 80 MHz the carrier runs at about 312.5 kHz, and each sample spans a non-integer number of periods. In locked mode the carrier period equals the sample-rate divisor, giving one period per sample, and each sample is rescaled to that period. A new sample is staged in a shadow register and reaches the compare register only at a period boundary. A missing sample at a strobe substitutes midscale and sets a sticky flag. The divisor and the mode are latched only at strobe boundaries.

Top module: `pcm_pwm_dac`

## Requirements
- R1: In free mode (cfg_locked = 0) the carrier period is 256 clocks. The output is high while the carrier count, which restarts at 0 each period, is below the sample value S, so it is high for S clocks of every period.
- R2: While enabled, smp_ready pulses for one clock every max(cfg_div, 4) clocks. A divisor of 5000 gives a 5000-clock spacing. At that pulse smp_data is taken when smp_valid is high.
- R3: In both modes, sample 0 keeps the output low for the whole period, and sample 255 keeps it high for the whole period.
- R4: In locked mode (cfg_locked = 1) the carrier period equals the divisor D, and the output is high for floor(S*D/256) clocks of each period.
- R5: The duty cycle changes only at a carrier period boundary. Every period aligned to the carrier shows either the old or the new sample, never a mix of the two.
- R6: When smp_valid is low at a strobe, the block loads midscale 128 as the duty value and sets the underrun flag.
- R7: The underrun flag stays set until underrun_clr is asserted, and then stays clear while samples keep arriving.
- R8: A new cfg_div or cfg_locked value takes effect only at the next strobe. The gap that is already running keeps the old divisor.
- R9: While enable is low, pwm_out and smp_ready stay low and both counters are held at zero. After enable rises, the first strobe comes D-1 clocks after the cycle in which enable rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable; low holds the counters and silences the output |
| cfg_div | input | DIV_W | Sample-rate divisor in clocks (values below 4 act as 4) |
| cfg_locked | input | 1 | 0 = free 256-clock carrier, 1 = carrier period equals the divisor |
| smp_data | input | SMP_W | Unsigned audio sample |
| smp_valid | input | 1 | Sample present on smp_data |
| smp_ready | output | 1 | Strobe; a sample is consumed in this cycle |
| underrun_clr | input | 1 | Clears the underrun flag |
| pwm_out | output | 1 | Modulated output to the filter |
| underrun | output | 1 | Sticky flag: a strobe found no valid sample |

## Verification
The assertions assume that the configuration only moves in ways the block is built to absorb. The divisor reaches the counters only at a strobe or while the block is disabled, so strobes are never closer than four clocks. That spacing is what lets the scaled compare value be registered in time. The bench changes the mode and the divisor only while disabled, or through the strobe-latched path in the R8 test. It keeps smp_valid high whenever it is not testing underrun, so each measured window sees a constant duty.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;

  typedef enum logic {
    MODE_FREE   = 1'b0,
    MODE_LOCKED = 1'b1
  } pwm_mode_e;

  localparam int unsigned MIN_DIVISOR = 4;

endpackage

// File: rtl/pwmdac_rate_gen.sv
module pwmdac_rate_gen
  import pwmdac_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfg_div,
  input  pwm_mode_e        cfg_mode,
  output logic [DIV_W-1:0] div_act,
  output pwm_mode_e        mode_act,
  output logic [DIV_W-1:0] rate_cnt,
  output logic             strobe
);

  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIVISOR);

  function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] d);
    return (d < DIV_FLOOR) ? DIV_FLOOR : d;
  endfunction

  logic             reload;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = clamp_div(cfg_div);
  assign strobe  = enable && (rate_cnt == div_act - DIV_W'(1));
  assign reload  = !enable || strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_cnt <= '0;
      div_act  <= DIV_FLOOR;
      mode_act <= MODE_FREE;
    end else begin
      if (reload) begin
        div_act  <= div_eff;
        mode_act <= cfg_mode;
        rate_cnt <= '0;
      end else begin
        rate_cnt <= rate_cnt + DIV_W'(1);
      end
    end
  end

  // R2: strobes never fall on consecutive cycles
  a_r2_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  // R8: the active configuration only moves at a strobe
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !strobe) |=> ($stable(div_act) && $stable(mode_act)));

  // R9: a disabled cycle restarts the divider
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (rate_cnt == '0));

endmodule

// File: rtl/pwmdac_sample_reg.sv
module pwmdac_sample_reg #(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             underrun_clr,
  input  logic [DIV_W-1:0] div_act,
  output logic [SMP_W-1:0] shadow,
  output logic [DIV_W-1:0] scaled_q,
  output logic             underrun
);

  localparam logic [SMP_W-1:0] MIDSCALE = SMP_W'(1) << (SMP_W - 1);

  function automatic logic [DIV_W-1:0] scale_duty(input logic [SMP_W-1:0] s,
                                                  input logic [DIV_W-1:0] d);
    logic [SMP_W+DIV_W-1:0] prod;
    prod = {{DIV_W{1'b0}}, s} * {{SMP_W{1'b0}}, d};
    return prod[SMP_W +: DIV_W];
  endfunction

  logic take_smp;
  logic starve;

  assign take_smp = strobe && smp_valid;
  assign starve   = strobe && !smp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= MIDSCALE;
      scaled_q <= '0;
      underrun <= 1'b0;
    end else begin
      if (take_smp)    shadow <= smp_data;
      else if (starve) shadow <= MIDSCALE;
      scaled_q <= scale_duty(shadow, div_act);
      if (starve)            underrun <= 1'b1;
      else if (underrun_clr) underrun <= 1'b0;
    end
  end

  // R2: an offered sample lands in the shadow register
  a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && smp_valid) |=> (shadow == $past(smp_data)));

  // R6: a starved strobe loads midscale and flags it
  a_r6_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !smp_valid) |=> (shadow == MIDSCALE && underrun));

  // R7: the flag only drops on request
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(underrun) |-> $past(underrun_clr));

endmodule

// File: rtl/pwmdac_carrier.sv
module pwmdac_carrier
  import pwmdac_pkg::*;
#(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  pwm_mode_e        mode_act,
  input  logic             strobe,
  input  logic [DIV_W-1:0] rate_cnt,
  input  logic [SMP_W-1:0] shadow,
  input  logic [DIV_W-1:0] scaled_q,
  output logic             boundary,
  output logic             pwm_out
);

  localparam logic [SMP_W-1:0] FULL_SCALE = {SMP_W{1'b1}};

  logic [SMP_W-1:0] pcnt;
  logic [DIV_W-1:0] cmp;
  logic             cmp_full;
  logic [DIV_W-1:0] carrier_cnt;
  logic             locked;

  assign locked      = (mode_act == MODE_LOCKED);
  assign carrier_cnt = locked ? rate_cnt : DIV_W'(pcnt);
  assign boundary    = enable && (locked ? strobe : (pcnt == FULL_SCALE));
  assign pwm_out     = enable && (cmp_full || (carrier_cnt < cmp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      cmp      <= '0;
      cmp_full <= 1'b0;
    end else if (!enable) begin
      pcnt     <= '0;
      cmp      <= '0;
      cmp_full <= 1'b0;
    end else begin
      pcnt <= pcnt + SMP_W'(1);
      if (boundary) begin
        cmp_full <= (shadow == FULL_SCALE);
        cmp      <= locked ? scaled_q : DIV_W'(shadow);
      end
    end
  end

  // R5: the compare value holds for the whole period
  a_r5_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !boundary) |=> ($stable(cmp) && $stable(cmp_full)));

  // R3: a zero sample committed at a boundary gives a dark output
  a_r3_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && shadow == '0) |=> !pwm_out);

  // R3: a full-scale sample committed at a boundary gives a lit output
  a_r3_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && shadow == FULL_SCALE) |=> (pwm_out || !enable));

endmodule

// File: rtl/pcm_pwm_dac.sv
module pcm_pwm_dac
  import pwmdac_pkg::*;
#(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_locked,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic             underrun_clr,
  output logic             pwm_out,
  output logic             underrun
);

  logic [DIV_W-1:0] div_act;
  pwm_mode_e        mode_act;
  logic [DIV_W-1:0] rate_cnt;
  logic             strobe;
  logic [SMP_W-1:0] shadow;
  logic [DIV_W-1:0] scaled_q;
  logic             boundary;

  pwmdac_rate_gen #(.DIV_W(DIV_W)) rate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cfg_div  (cfg_div),
    .cfg_mode (pwm_mode_e'(cfg_locked)),
    .div_act  (div_act),
    .mode_act (mode_act),
    .rate_cnt (rate_cnt),
    .strobe   (strobe)
  );

  pwmdac_sample_reg #(.SMP_W(SMP_W), .DIV_W(DIV_W)) smp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .smp_valid    (smp_valid),
    .smp_data     (smp_data),
    .underrun_clr (underrun_clr),
    .div_act      (div_act),
    .shadow       (shadow),
    .scaled_q     (scaled_q),
    .underrun     (underrun)
  );

  pwmdac_carrier #(.SMP_W(SMP_W), .DIV_W(DIV_W)) car_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .mode_act (mode_act),
    .strobe   (strobe),
    .rate_cnt (rate_cnt),
    .shadow   (shadow),
    .scaled_q (scaled_q),
    .boundary (boundary),
    .pwm_out  (pwm_out)
  );

  assign smp_ready = strobe;

  // R9: nothing is consumed or driven while disabled
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (rate_cnt == '0 && !boundary));

endmodule

// File: tb/pcm_pwm_dac_tb_top.sv
module pcm_pwm_dac_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SMP_W = 8;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             enable = 1'b0;
  logic [DIV_W-1:0] cfg_div = 16'd64;
  logic             cfg_locked = 1'b0;
  logic [SMP_W-1:0] smp_data = '0;
  logic             smp_valid = 1'b0;
  logic             smp_ready;
  logic             underrun_clr = 1'b0;
  logic             pwm_out;
  logic             underrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_pwm_dac #(.SMP_W(SMP_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
    .cfg_locked(cfg_locked), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .underrun_clr(underrun_clr),
    .pwm_out(pwm_out), .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic high_count(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      h += int'(pwm_out);
    end
  endtask

  task automatic setup(input bit locked, input int div);
    @(negedge clk);
    enable = 1'b0;
    cfg_locked = locked;
    cfg_div = DIV_W'(div);
    cycles(3);
    enable = 1'b1;
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!smp_ready);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!smp_ready);
  endtask

  function automatic int free_high(input int s);
    return (s == 255) ? 256 : s;
  endfunction

  function automatic int locked_high(input int s, input int d);
    return (s == 255) ? d : (s * d) / 256;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h, g, k, prev;
    int s_list[7];
    int d_list[4];
    s_list = '{0, 1, 64, 128, 200, 254, 255};
    d_list = '{100, 37, 256, 300};

    // R9: reset state
    cycles(3);
    check(!pwm_out && !smp_ready && !underrun, "R9 reset", int'(pwm_out), 0);
    @(negedge clk) rst_n = 1'b1;
    cycles(2);

    // R1 / R3: free-mode duty sweep
    smp_valid = 1'b1;
    setup(1'b0, 64);
    for (int s = 0; s < 260; s += 5) begin
      int sv;
      sv = (s > 255) ? 255 : s;
      smp_data = SMP_W'(sv);
      cycles(400);
      high_count(256, h);
      check(h == free_high(sv), (sv == 0 || sv == 255) ? "R3 free edge" : "R1 free duty", h, free_high(sv));
    end
    foreach (s_list[i]) begin
      smp_data = SMP_W'(s_list[i]);
      cycles(400);
      high_count(256, h);
      check(h == free_high(s_list[i]), "R1 free duty list", h, free_high(s_list[i]));
    end

    // R9: disabled output and ready stay low
    smp_data = 8'd255;
    cycles(400);
    @(negedge clk) enable = 1'b0;
    k = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      k += int'(pwm_out) + int'(smp_ready);
    end
    check(k == 0, "R9 disabled quiet", k, 0);

    // R9: first strobe after enable
    cfg_div = 16'd50;
    cycles(2);
    enable = 1'b1;
    #1;
    k = 0;
    while (!smp_ready) begin @(negedge clk); k++; end
    check(k == 49, "R9 first strobe", k, 49);

    // R2: strobe spacing
    gap(g);
    check(g == 50, "R2 gap 50", g, 50);
    setup(1'b0, 2);
    wait_ready();
    gap(g);
    check(g == 4, "R2 clamp to 4", g, 4);
    setup(1'b0, 5000);
    wait_ready();
    gap(g);
    check(g == 5000, "R2 gap 5000", g, 5000);

    // R8: divisor change waits for the strobe
    setup(1'b0, 50);
    wait_ready();
    @(negedge clk);
    g = 1;
    cfg_div = 16'd80;
    while (!smp_ready) begin @(negedge clk); g++; end
    check(g == 50, "R8 old divisor holds", g, 50);
    gap(g);
    check(g == 80, "R8 new divisor applied", g, 80);

    // R4 / R3: locked mode
    foreach (d_list[j]) begin
      setup(1'b1, d_list[j]);
      foreach (s_list[i]) begin
        smp_data = SMP_W'(s_list[i]);
        cycles(3 * d_list[j] + 8);
        high_count(d_list[j], h);
        check(h == locked_high(s_list[i], d_list[j]),
              (s_list[i] == 0 || s_list[i] == 255) ? "R3 locked edge" : "R4 locked duty",
              h, locked_high(s_list[i], d_list[j]));
      end
    end

    // R5: aligned periods carry one sample only
    setup(1'b0, 64);
    smp_data = 8'd40;
    cycles(400);
    prev = 1;
    do begin prev = int'(pwm_out); @(negedge clk); end while (!(pwm_out && prev == 0));
    h = 1;
    for (int i = 0; i < 255; i++) begin @(negedge clk); h += int'(pwm_out); end
    check(h == 40, "R5 aligned old", h, 40);
    smp_data = 8'd200;
    for (int w = 0; w < 5; w++) begin
      high_count(256, h);
      check(h == 40 || h == 200, "R5 no mixed period", h, 200);
    end
    check(h == 200, "R5 new sample reached", h, 200);

    // R6: starvation gives midscale and the flag
    smp_valid = 1'b0;
    cycles(100);
    check(underrun == 1'b1, "R6 flag set", int'(underrun), 1);
    cycles(400);
    high_count(256, h);
    check(h == 128, "R6 midscale duty", h, 128);

    // R7: sticky until cleared
    smp_valid = 1'b1;
    smp_data = 8'd10;
    cycles(200);
    check(underrun == 1'b1, "R7 sticky", int'(underrun), 1);
    underrun_clr = 1'b1;
    @(negedge clk) underrun_clr = 1'b0;
    check(underrun == 1'b0, "R7 cleared", int'(underrun), 0);
    cycles(300);
    check(underrun == 1'b0, "R7 stays clear", int'(underrun), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule